// File: doc/BRIEF.md
# Page Table Tree Enumerator

This engine walks a whole 64-bit hierarchical translation tree, starting from a root pointer. It lists every present leaf mapping it finds. The walk is depth first. Each table is scanned from index 0 upward. When the engine meets a present entry that points to another table, it descends into that table and later resumes the parent at the next index. Table entries are fetched one at a time through a plain request/response read port. Every present leaf produces one output record holding a virtual address, a physical address and a page size code. Records leave through a valid/ready handshake, and the engine waits whenever the consumer is not ready.

A one-cycle start pulse captures the root value, the mode (four levels or three levels) and an address mask. The mask is applied to every fetch address and to every next-level table base. Three-level mode starts at a small four-entry root table whose entries always point to directory tables. A one-cycle done pulse follows the final entry of the root table. The engine then goes idle and accepts a new start.

Top module: `ptw_enum`

## Requirements
- R1: A start pulse while idle captures `root_ptr`, `three_lvl` and `fetch_mask`. In four-level mode the root table base is `root_ptr` bits 51:12. Each entry at index i (0..511, ascending) is read from `(base + 8*i) & fetch_mask`. A start pulse while a walk is running is ignored.
- R2: Each next-level table base is also ANDed with the captured mask. Reported physical addresses are not masked.
- R3: An entry with bit 0 clear is not present. It is skipped with no descent and no record, and the walk moves to the next index.
- R4: A present entry that points to another table gives that table's base as entry bits 51:12. Bits 63:52 and 11:0 are dropped.
- R5: At the third level (below the top), a present entry with bit 7 set is a 1 GiB leaf. Its record has `rec_size` = 2 and a physical address equal to the entry with bits 29:0 and bit 63 cleared.
- R6: At the directory level, a present entry with bit 7 set is a 2 MiB leaf. Its record has `rec_size` = 1 and a physical address equal to the entry with bits 20:0 and bit 63 cleared.
- R7: Every present entry at the last level is a 4 KiB leaf, whatever bit 7 holds. Its record has `rec_size` = 0 and a physical address equal to the entry with bits 11:0 and bit 63 cleared.
- R8: In four-level mode the record's virtual address holds the top index in bits 47:39, the third-level index in bits 38:30, the directory index in bits 29:21 and the last-level index in bits 20:12. Levels below the leaf contribute zeros, and bits 63:48 are all ones.
- R9: In three-level mode the root base is `root_ptr` with bits 4:0 cleared, and the root has 4 entries of 8 bytes. A present root entry always descends to a directory table (bits 51:12), even with bit 7 set. The root index fills virtual bits 31:30, and virtual bits 63:32 are zero.
- R10: Records leave in depth-first order. While `rec_valid` is high and `rec_ready` is low, the record stays unchanged and the walk does not advance.
- R11: At most one read is outstanding. `req_valid` stays low from the accepted request until `rsp_valid`. A request that is not accepted keeps the same address.
- R12: `done` is high for exactly one cycle after the last root entry has been handled. No request follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (honoured only while idle) |
| root_ptr | input | 64 | Root table pointer value |
| three_lvl | input | 1 | 1 = three-level mode with a 4-entry root |
| fetch_mask | input | 64 | Mask ANDed into fetch addresses and table bases |
| req_valid | output | 1 | Entry read request |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 64 | Byte address of the entry to read |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | 64 | Entry value |
| rec_valid | output | 1 | Mapping record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_vaddr | output | 64 | Virtual address of the mapping |
| rec_paddr | output | 64 | Physical address of the mapping |
| rec_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| done | output | 1 | One-cycle pulse at the end of a walk |

## Verification
The bench builds sparse trees whose entries carry junk in bits 63:52, in the low flag bits and in bit 7 at the last level. A design that forgets to strip those bits reports wrong physical addresses or descends into wrong tables, and the exact record and fetch-count comparisons expose this. One tree places a 2 MiB leaf before a further descent and a 1 GiB leaf after a whole subtree. A design that loses its parent index after returning from a lower level reports records out of order, repeats tables or stops early. Other runs use a 32-bit mask with root and entry bases above bit 31, a three-level root whose entry has bit 7 set, and back-pressure on both ports. These catch a missing mask on bases, a three-level walk that treats a root entry as a 1 GiB leaf or scans 512 root entries, and a design that advances while stalled.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PTE_W      = 64;
    localparam int IDX_W      = 9;
    localparam int NLVL       = 4;
    localparam int PG_SHIFT   = 12;
    localparam int ENT_SH     = 3;
    localparam int PRES_BIT   = 0;
    localparam int HUGE_BIT   = 7;
    localparam int NX_BIT     = 63;
    localparam int BASE_HI    = 51;
    localparam int ROOT3_N    = 4;
    localparam int ROOT3_W    = $clog2(ROOT3_N);
    localparam int ROOT3_CLRW = 5;
    localparam int LVL_W      = $clog2(NLVL);

    localparam logic [PTE_W-1:0] BASE_FIELD =
        ((64'd1 << (BASE_HI + 1)) - 64'd1) & ~((64'd1 << PG_SHIFT) - 64'd1);
    localparam logic [PTE_W-1:0] ROOT3_FIELD = ~((64'd1 << ROOT3_CLRW) - 64'd1);

    typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2} pg_size_e;
    typedef enum logic [1:0] {ACT_SKIP, ACT_DOWN, ACT_LEAF} ent_act_e;
    typedef enum logic [2:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_EMIT, ST_NEXT, ST_DONE} walk_st_e;

    typedef struct packed {
        walk_st_e                         st;
        logic [LVL_W-1:0]                 lvl;
        logic                             three;
        logic [PTE_W-1:0]                 mask;
        logic [NLVL-1:0][IDX_W-1:0]       idx;
        logic [NLVL-1:0][PTE_W-1:0]       base;
        logic [PTE_W-1:0]                 rvaddr;
        logic [PTE_W-1:0]                 rpaddr;
        pg_size_e                         rsize;
    } walk_s;
endpackage

// File: rtl/ptw_fetch_addr.sv
module ptw_fetch_addr
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    input  logic [PTE_W-1:0] mask,
    output logic [PTE_W-1:0] addr
);
    localparam int PAD_W = PTE_W - IDX_W;
    logic [PTE_W-1:0] offs;

    always_comb begin
        offs = {{PAD_W{1'b0}}, idx} << ENT_SH;
        addr = (base + offs) & mask;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] entry,
    input  logic [LVL_W-1:0] lvl,
    input  logic             three,
    input  logic [PTE_W-1:0] mask,
    output ent_act_e         act,
    output pg_size_e         size,
    output logic [PTE_W-1:0] paddr,
    output logic [PTE_W-1:0] next_base
);
    int unsigned      keep_sh;
    logic [PTE_W-1:0] low_bits;

    always_comb begin
        act  = ACT_SKIP;
        size = SZ_4K;
        if (entry[PRES_BIT]) begin
            if (lvl == LVL_W'(NLVL - 1)) begin
                act = ACT_LEAF;
            end else if (lvl == LVL_W'(NLVL - 2) && entry[HUGE_BIT]) begin
                act  = ACT_LEAF;
                size = SZ_2M;
            end else if (lvl == LVL_W'(NLVL - 3) && entry[HUGE_BIT] && !three) begin
                act  = ACT_LEAF;
                size = SZ_1G;
            end else begin
                act = ACT_DOWN;
            end
        end
        keep_sh           = PG_SHIFT + IDX_W * int'(size);
        low_bits          = (64'd1 << keep_sh) - 64'd1;
        paddr             = entry & ~low_bits;
        paddr[NX_BIT]     = 1'b0;
        next_base         = entry & BASE_FIELD & mask;
    end
endmodule

// File: rtl/ptw_vaddr_build.sv
module ptw_vaddr_build
    import ptw_pkg::*;
(
    input  logic [NLVL-1:0][IDX_W-1:0] idx,
    input  logic [LVL_W-1:0]           lvl,
    input  logic                       three,
    output logic [PTE_W-1:0]           vaddr
);
    logic [NLVL-1:0][IDX_W-1:0] kept;

    always_comb begin
        for (int k = 0; k < NLVL; k++) begin
            kept[k] = (k <= int'(lvl)) ? idx[k] : '0;
        end
        vaddr = three ? '0 : '1;
        for (int k = 0; k < NLVL; k++) begin
            if (!three || k >= 2) begin
                vaddr[PG_SHIFT + IDX_W * (NLVL - 1 - k) +: IDX_W] = kept[k];
            end
        end
        if (three) begin
            vaddr[PG_SHIFT + IDX_W * (NLVL - 2) +: ROOT3_W] = kept[1][ROOT3_W-1:0];
        end
        vaddr[PG_SHIFT-1:0] = '0;
    end
endmodule

// File: rtl/ptw_enum.sv
module ptw_enum
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [63:0]      root_ptr,
    input  logic             three_lvl,
    input  logic [63:0]      fetch_mask,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [63:0]      req_addr,
    input  logic             rsp_valid,
    input  logic [63:0]      rsp_data,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [63:0]      rec_vaddr,
    output logic [63:0]      rec_paddr,
    output logic [1:0]       rec_size,
    output logic             done
);
    walk_s            q, d;
    ent_act_e         dec_act;
    pg_size_e         dec_size;
    logic [PTE_W-1:0] dec_paddr, dec_next, cur_vaddr;
    logic [IDX_W-1:0] last_idx;
    logic [LVL_W-1:0] top_lvl, dn_lvl;

    ptw_fetch_addr u_fetch (
        .base (q.base[q.lvl]),
        .idx  (q.idx[q.lvl]),
        .mask (q.mask),
        .addr (req_addr)
    );

    ptw_entry_decode u_dec (
        .entry     (rsp_data),
        .lvl       (q.lvl),
        .three     (q.three),
        .mask      (q.mask),
        .act       (dec_act),
        .size      (dec_size),
        .paddr     (dec_paddr),
        .next_base (dec_next)
    );

    ptw_vaddr_build u_va (
        .idx   (q.idx),
        .lvl   (q.lvl),
        .three (q.three),
        .vaddr (cur_vaddr)
    );

    always_comb begin
        d        = q;
        top_lvl  = q.three ? LVL_W'(1) : LVL_W'(0);
        last_idx = (q.three && q.lvl == LVL_W'(1)) ? IDX_W'(ROOT3_N - 1) : '1;
        dn_lvl   = q.lvl + LVL_W'(1);
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.three = three_lvl;
                    d.mask  = fetch_mask;
                    d.idx   = '0;
                    d.st    = ST_REQ;
                    if (three_lvl) begin
                        d.lvl     = LVL_W'(1);
                        d.base[1] = root_ptr & ROOT3_FIELD & fetch_mask;
                    end else begin
                        d.lvl     = '0;
                        d.base[0] = root_ptr & BASE_FIELD & fetch_mask;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    unique case (dec_act)
                        ACT_LEAF: begin
                            d.rvaddr = cur_vaddr;
                            d.rpaddr = dec_paddr;
                            d.rsize  = dec_size;
                            d.st     = ST_EMIT;
                        end
                        ACT_DOWN: begin
                            d.lvl          = dn_lvl;
                            d.base[dn_lvl] = dec_next;
                            d.idx[dn_lvl]  = '0;
                            d.st           = ST_REQ;
                        end
                        default: d.st = ST_NEXT;
                    endcase
                end
            end
            ST_EMIT: begin
                if (rec_ready) d.st = ST_NEXT;
            end
            ST_NEXT: begin
                if (q.idx[q.lvl] == last_idx) begin
                    if (q.lvl == top_lvl) d.st = ST_DONE;
                    else                  d.lvl = q.lvl - LVL_W'(1);
                end else begin
                    d.idx[q.lvl] = q.idx[q.lvl] + IDX_W'(1);
                    d.st         = ST_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_valid = (q.st == ST_REQ);
    assign rec_valid = (q.st == ST_EMIT);
    assign rec_vaddr = q.rvaddr;
    assign rec_paddr = q.rpaddr;
    assign rec_size  = q.rsize;
    assign done      = (q.st == ST_DONE);
endmodule

// File: rtl/ptw_enum_checker.sv
module ptw_enum_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        three_lvl,
    input logic [63:0] fetch_mask,
    input logic        req_valid,
    input logic        req_ready,
    input logic [63:0] req_addr,
    input logic        rsp_valid,
    input logic        rec_valid,
    input logic        rec_ready,
    input logic [63:0] rec_vaddr,
    input logic [63:0] rec_paddr,
    input logic [1:0]  rec_size,
    input logic        done
);
    logic        active_q, three_q, outs_q;
    logic [63:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            three_q  <= 1'b0;
            mask_q   <= '0;
            outs_q   <= 1'b0;
        end else begin
            if (start && !active_q) begin
                active_q <= 1'b1;
                three_q  <= three_lvl;
                mask_q   <= fetch_mask;
            end else if (done) begin
                active_q <= 1'b0;
            end
            if (req_valid && req_ready) outs_q <= 1'b1;
            else if (rsp_valid)         outs_q <= 1'b0;
        end
    end

    assert_one_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        outs_q |-> !req_valid);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));

    assert_rec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_vaddr)
                                   && $stable(rec_paddr) && $stable(rec_size));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !req_valid);

    assert_fetch_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr & ~mask_q) == 64'd0) && (req_addr[2:0] == 3'd0));

    // R5, R6, R7: leaf physical addresses are aligned to their size, bit 63 clear
    assert_leaf_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> !rec_paddr[63] && (rec_size != 2'd3)
            && ((rec_size == 2'd0) ? (rec_paddr[11:0] == 12'd0) :
                (rec_size == 2'd1) ? (rec_paddr[20:0] == 21'd0) :
                                     (rec_paddr[29:0] == 30'd0)));

    assert_vaddr_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && !three_q |-> (&rec_vaddr[63:48]) && (rec_vaddr[11:0] == 12'd0));

    assert_vaddr_low32_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid && three_q |-> (rec_vaddr[63:32] == 32'd0) && (rec_size != 2'd2));
endmodule

bind ptw_enum ptw_enum_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .three_lvl  (three_lvl),
    .fetch_mask (fetch_mask),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rec_valid  (rec_valid),
    .rec_ready  (rec_ready),
    .rec_vaddr  (rec_vaddr),
    .rec_paddr  (rec_paddr),
    .rec_size   (rec_size),
    .done       (done)
);

// File: tb/ptw_enum_bench.sv
module ptw_enum_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] root_ptr = '0;
    logic        three_lvl = 1'b0;
    logic [63:0] fetch_mask = '1;
    logic        req_valid, req_ready;
    logic [63:0] req_addr;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rec_valid, rec_ready;
    logic [63:0] rec_vaddr, rec_paddr;
    logic [1:0]  rec_size;
    logic        done;

    always #4 clk = ~clk;

    ptw_enum u_ptw_enum (
        .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr),
        .three_lvl(three_lvl), .fetch_mask(fetch_mask),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_vaddr(rec_vaddr), .rec_paddr(rec_paddr), .rec_size(rec_size),
        .done(done)
    );

    int checks = 0;
    int errors = 0;

    // sparse memory: absent addresses read as zero
    logic [63:0] mem_a [32];
    logic [63:0] mem_d [32];
    int          mem_n = 0;

    // observation logs
    int          nfetch, nrec, ndone, cyc;
    logic [63:0] first_fetch, last_fetch, or_fetch;
    logic [63:0] lv [16];
    logic [63:0] lp [16];
    logic [1:0]  ls [16];
    bit          stall_en = 1'b0;

    bit          pend = 1'b0;
    logic [63:0] pend_addr;
    int          pend_lat;

    function automatic logic [63:0] lookup(input logic [63:0] a);
        for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) return mem_d[i];
        return 64'd0;
    endfunction

    task automatic put(input logic [63:0] a, input logic [63:0] v);
        mem_a[mem_n] = a;
        mem_d[mem_n] = v;
        mem_n++;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder and port monitor, all at the falling edge
    initial begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rec_ready = 1'b0;
        cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rsp_valid = 1'b0;
            if (pend) begin
                if (pend_lat == 0) begin
                    rsp_valid = 1'b1;
                    rsp_data  = lookup(pend_addr);
                    pend      = 1'b0;
                end else begin
                    pend_lat--;
                end
            end
            req_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
            if (req_valid && req_ready && !pend) begin
                pend      = 1'b1;
                pend_addr = req_addr;
                pend_lat  = stall_en ? (cyc % 2) : 0;
                if (nfetch == 0) first_fetch = req_addr;
                last_fetch = req_addr;
                or_fetch   = or_fetch | req_addr;
                nfetch++;
            end
            rec_ready = stall_en ? (cyc % 5 == 0) : 1'b1;
            if (rec_valid && rec_ready) begin
                if (nrec < 16) begin
                    lv[nrec] = rec_vaddr;
                    lp[nrec] = rec_paddr;
                    ls[nrec] = rec_size;
                end
                nrec++;
            end
            if (done) ndone++;
        end
    end

    task automatic run_walk(input logic [63:0] root, input bit three,
                            input logic [63:0] mask, input bit stall);
        nfetch = 0; nrec = 0; ndone = 0; or_fetch = '0;
        first_fetch = '0; last_fetch = '0;
        stall_en = stall;
        @(negedge clk); #1;
        root_ptr = root; three_lvl = three; fetch_mask = mask; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        // a second start in mid-walk must be ignored (R1)
        repeat (3) @(negedge clk);
        #1;
        root_ptr = 64'hDEAD_0000; three_lvl = ~three; fetch_mask = '0; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (ndone == 0) begin
            @(negedge clk); #1;
        end
        repeat (12) @(negedge clk);
        #1;
        chk(ndone == 1, "R12", "done pulse count", 64'(ndone), 64'd1);
        chk(!req_valid && !rec_valid, "R12", "quiet after done",
            {62'd0, req_valid, rec_valid}, 64'd0);
    endtask

    task automatic t_reset;
        chk(!req_valid && !rec_valid && !done, "R12", "reset outputs",
            {61'd0, req_valid, rec_valid, done}, 64'd0);
    endtask

    task automatic t_four_level;
        mem_n = 0;
        put(64'h1008, 64'h0000_0000_0000_2001);          // top[1] -> 0x2000
        put(64'h1028, 64'h0000_0000_0000_9080);          // top[5] absent (R3)
        put(64'h2000, 64'h0000_0000_0000_3001);          // third[0] -> 0x3000
        put(64'h2018, 64'h8000_0001_4012_3083);          // third[3] 1 GiB
        put(64'h3010, 64'h8000_0000_0060_1081);          // dir[2] 2 MiB
        put(64'h3038, 64'h8010_0000_0000_4E01);          // dir[7] -> 0x4000 (R4)
        put(64'h4000, 64'h8000_0000_0ABC_D1FF);          // leaf[0] bit7 set
        put(64'h4FF8, 64'h0000_0000_1234_5001);          // leaf[511]
        run_walk(64'h8000_0000_0000_1ABC, 1'b0, '1, 1'b0);
        chk(first_fetch == 64'h1000, "R1", "root base from bits 51:12", first_fetch, 64'h1000);
        chk(last_fetch == 64'h1FF8, "R1", "last root entry fetch", last_fetch, 64'h1FF8);
        chk(nfetch == 2048, "R3", "fetch count four-level", 64'(nfetch), 64'd2048);
        chk(nrec == 4, "R10", "record count", 64'(nrec), 64'd4);
        chk(lv[0] == 64'hFFFF_0080_0040_0000, "R8", "2M vaddr", lv[0], 64'hFFFF_0080_0040_0000);
        chk(lp[0] == 64'h0060_0000 && ls[0] == 2'd1, "R6", "2M leaf", lp[0], 64'h0060_0000);
        chk(lv[1] == 64'hFFFF_0080_00E0_0000, "R10", "first 4K vaddr", lv[1], 64'hFFFF_0080_00E0_0000);
        chk(lp[1] == 64'h0ABC_D000 && ls[1] == 2'd0, "R7", "4K leaf with bit7", lp[1], 64'h0ABC_D000);
        chk(lv[2] == 64'hFFFF_0080_00FF_F000, "R8", "last 4K vaddr", lv[2], 64'hFFFF_0080_00FF_F000);
        chk(lp[2] == 64'h1234_5000, "R7", "last 4K paddr", lp[2], 64'h1234_5000);
        chk(lv[3] == 64'hFFFF_0080_C000_0000, "R10", "1G after subtree", lv[3], 64'hFFFF_0080_C000_0000);
        chk(lp[3] == 64'h1_4000_0000 && ls[3] == 2'd2, "R5", "1G leaf", lp[3], 64'h1_4000_0000);
    endtask

    task automatic t_masked_stalled;
        mem_n = 0;
        put(64'h5000, 64'h0000_0003_0000_6001);
        put(64'h6000, 64'h0000_0001_0000_7001);
        put(64'h7008, 64'h0000_0002_0000_8001);
        put(64'h8020, 64'h0000_0009_1111_1001);
        run_walk(64'h0000_0007_0000_5000, 1'b0, 64'h0000_0000_FFFF_FFFF, 1'b1);
        chk(first_fetch == 64'h5000, "R1", "masked root", first_fetch, 64'h5000);
        chk(or_fetch[63:32] == 32'd0, "R2", "all fetches masked", or_fetch, 64'h0);
        chk(nfetch == 2048, "R2", "masked bases reach all tables", 64'(nfetch), 64'd2048);
        chk(nrec == 1, "R10", "stalled record count", 64'(nrec), 64'd1);
        chk(lv[0] == 64'hFFFF_0000_0020_4000, "R8", "stalled vaddr", lv[0], 64'hFFFF_0000_0020_4000);
        chk(lp[0] == 64'h9_1111_1000, "R2", "paddr not masked", lp[0], 64'h9_1111_1000);
    endtask

    task automatic t_three_level;
        mem_n = 0;
        put(64'hA030, 64'h0000_0000_0000_B081);          // root[2] bit7 set, descends
        put(64'hA038, 64'h0000_0000_0000_D001);          // root[3] -> empty dir
        put(64'hB028, 64'h0000_0000_0020_0081);          // dir[5] 2 MiB
        run_walk(64'h0000_0000_0000_A03F, 1'b1, '1, 1'b0);
        chk(first_fetch == 64'hA020, "R9", "root base bits 4:0 cleared", first_fetch, 64'hA020);
        chk(nfetch == 1028, "R9", "four root entries", 64'(nfetch), 64'd1028);
        chk(last_fetch == 64'hDFF8, "R9", "last fetch in last dir", last_fetch, 64'hDFF8);
        chk(nrec == 1, "R9", "record count", 64'(nrec), 64'd1);
        chk(lv[0] == 64'h0000_0000_80A0_0000, "R9", "three-level vaddr", lv[0], 64'h80A0_0000);
        chk(lp[0] == 64'h0020_0000 && ls[0] == 2'd1, "R6", "three-level 2M", lp[0], 64'h0020_0000);
    endtask

    task automatic t_empty;
        mem_n = 0;
        put(64'h2_0010, 64'h0000_0000_0000_3000);        // bit 0 clear
        run_walk(64'h0000_0000_0002_0000, 1'b0, '1, 1'b0);
        chk(nfetch == 512, "R3", "absent entries not descended", 64'(nfetch), 64'd512);
        chk(nrec == 0, "R3", "no records", 64'(nrec), 64'd0);
        chk(last_fetch == 64'h2_0FF8, "R1", "ascending order end", last_fetch, 64'h2_0FF8);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset();
        t_four_level();
        t_masked_stalled();
        t_three_level();
        t_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule